// File: doc/BRIEF.md
# Tap-Packed Pixel Unpacker

This block sits behind the deserialiser of a frame-grabber video path. Each clock it takes one parallel word made of eight byte-wide taps, plus three qualifiers: frame active, line active and word valid. It splits the word into separate pixel values. A configured pixel format and a configured bus width decide how many pixels the word holds and which tap bits make up each pixel. The result comes out as up to eight 16-bit pixel lanes with a lane-valid mask. The qualifiers are carried alongside with the same one-cycle latency.

Four formats are supported: 8-bit mono, 16-bit mono, 12-bit packed and 24-bit colour. Pixels of 10 bits travel in the 12-bit packed layout, and pixels of 14 bits travel in the 16-bit layout, so the same two modes serve them. The bus width limits how many taps carry data: 3 taps, 6 taps or 8 taps. A reserved width code carries no taps at all.

Top module: `tap_pixel_unpacker`

## Requirements
- R1: Tap k occupies bits 8k+7..8k of `tap_data_i` (tap A at k=0). With format code 0 (8-bit), lane i carries tap i zero-extended. The valid pixel count is 3, 6 or 8 for bus codes 0, 1 and 2.
- R2: With format code 1 (16-bit), lane i carries tap 2i+1 as its high byte and tap 2i as its low byte, with no reordering. The valid pixel count is 1, 3 or 4 for bus codes 0, 1 and 2.
- R3: With format code 2 (12-bit packed), the low bytes of lanes 0, 1, 2 and 3 come from taps 0, 2, 4 and 3. Their upper nibbles come from tap 1 bits 3..0, tap 1 bits 7..4, tap 5 bits 3..0 and tap 5 bits 7..4, placed in lane bits 11..8. Lane bits 15..12 read zero. The valid pixel count is 2 for bus code 0 and 4 for bus codes 1 and 2.
- R4: With format code 3 (24-bit colour), lanes 0, 1 and 2 carry red from tap 0, green from tap 2 and blue from tap 1. Lanes 3, 4 and 5 carry red, green and blue from taps 3, 5 and 4. The valid pixel count is 1 for bus code 0 and 2 for bus codes 1 and 2, with three lanes set per pixel.
- R5: `lane_vld_o` is always a contiguous run of ones starting at lane 0, and its length equals the valid lane count of R1 to R4.
- R6: `fv_o`, `lv_o` and `dv_o` equal `fv_i`, `lv_i` and `dv_i` from one clock earlier.
- R7: A word is taken only when all three qualifiers are high. In any other cycle the lane mask is zero one clock later and the lane data keep their previous values.
- R8: Bus code 3 is reserved and provides no taps. Any format whose tap need exceeds the taps provided raises `cfg_err_o` one clock later, gives a zero lane mask and leaves the lane data unchanged, whatever the qualifiers are.
- R9: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_fmt_i | input | 2 | Format: 0 8-bit, 1 16-bit, 2 12-bit packed, 3 24-bit colour |
| bus_cfg_i | input | 2 | Bus width: 0 three taps, 1 six taps, 2 eight taps, 3 reserved |
| tap_data_i | input | 64 | Eight taps, tap 0 in the low byte |
| fv_i | input | 1 | Frame active |
| lv_i | input | 1 | Line active |
| dv_i | input | 1 | Word valid |
| fv_o | output | 1 | Frame active, delayed one clock |
| lv_o | output | 1 | Line active, delayed one clock |
| dv_o | output | 1 | Word valid, delayed one clock |
| lane_data_o | output | 128 | Eight 16-bit lanes, lane 0 in the low bits |
| lane_vld_o | output | 8 | Per-lane valid mask |
| cfg_err_o | output | 1 | Format needs more taps than the bus provides |

## Verification
Three events can land on the same clock edge: a change of format or bus width, a fully qualified word, and a switch to a configuration the bus cannot carry. The bench changes format and bus code together with the data on every random cycle, so the new setting must apply to that same word. It also forces the reserved bus code while all qualifiers are high. In that case the error must win: the bench expects a zero mask with the last good lane values held, and then a clean first word as soon as a legal setting returns.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

   typedef enum logic [1:0] {
      FMT_MONO8  = 2'd0,
      FMT_MONO16 = 2'd1,
      FMT_PACK12 = 2'd2,
      FMT_RGB24  = 2'd3
   } pix_fmt_e;

   typedef enum logic [1:0] {
      BUS_NARROW = 2'd0,
      BUS_MID    = 2'd1,
      BUS_WIDE   = 2'd2,
      BUS_RSVD   = 2'd3
   } bus_cfg_e;

   typedef struct packed {
      logic fv;
      logic lv;
      logic dv;
   } qual_t;

   // Minimum tap count a format needs to yield one pixel.
   function automatic int unsigned fmt_need_taps(pix_fmt_e f);
      case (f)
         FMT_MONO8:  return 1;
         FMT_MONO16: return 2;
         default:    return 3;
      endcase
   endfunction

endpackage

// File: rtl/tpu_cfg_decode.sv
module tpu_cfg_decode
   import tpu_pkg::*;
#(
   parameter int NUM_TAPS  = 8,
   parameter int BASE_TAPS = 3,
   parameter int MED_TAPS  = 6,
   parameter int LANES     = 8
) (
   input  pix_fmt_e          fmt,
   input  bus_cfg_e          bus,
   output logic [LANES-1:0]  mask,
   output logic              cfg_err
);

   localparam int PK12_MAX = 4;   // nibble taps hold four upper nibbles
   localparam int RGB_MAX  = LANES / 3;

   int unsigned avail;
   int unsigned cnt;

   always_comb begin
      case (bus)
         BUS_NARROW: avail = BASE_TAPS;
         BUS_MID:    avail = MED_TAPS;
         BUS_WIDE:   avail = NUM_TAPS;
         default:    avail = 0;
      endcase
   end

   always_comb begin
      case (fmt)
         FMT_MONO8:  cnt = avail;
         FMT_MONO16: cnt = avail / 2;
         FMT_PACK12: cnt = ((avail / 3) * 2 > PK12_MAX) ? PK12_MAX : (avail / 3) * 2;
         default:    cnt = ((avail / 3) > RGB_MAX) ? RGB_MAX * 3 : (avail / 3) * 3;
      endcase
   end

   assign cfg_err = fmt_need_taps(fmt) > avail;

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign mask[i] = !cfg_err && (i < cnt);
   end

endmodule

// File: rtl/tpu_lane_mux.sv
module tpu_lane_mux
   import tpu_pkg::*;
#(
   parameter int TAP_W    = 8,
   parameter int NUM_TAPS = 8,
   parameter int LANES    = 8,
   parameter int LANE_W   = 16
) (
   input  pix_fmt_e                     fmt,
   input  logic [NUM_TAPS*TAP_W-1:0]    taps,
   output logic [LANES*LANE_W-1:0]      lanes
);

   localparam int NIB_W = TAP_W / 2;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] v8, v16, v12, vrgb;

      if (i < NUM_TAPS) begin : g_m8
         assign v8 = LANE_W'(taps[i*TAP_W +: TAP_W]);
      end else begin : g_m8z
         assign v8 = '0;
      end

      if (2*i+1 < NUM_TAPS) begin : g_m16
         assign v16 = LANE_W'({taps[(2*i+1)*TAP_W +: TAP_W],
                               taps[(2*i)*TAP_W +: TAP_W]});
      end else begin : g_m16z
         assign v16 = '0;
      end

      if (i < 4) begin : g_p12
         // low-byte taps in non-sequential order, nibble taps 1 and 5
         localparam int LO = (i == 0) ? 0 : (i == 1) ? 2 : (i == 2) ? 4 : 3;
         localparam int NB = (i < 2) ? 1 : 5;
         localparam int SH = (i % 2) * NIB_W;
         assign v12 = LANE_W'({taps[NB*TAP_W+SH +: NIB_W],
                               taps[LO*TAP_W +: TAP_W]});
      end else begin : g_p12z
         assign v12 = '0;
      end

      // colour channel order on the taps is red, blue, green
      localparam int GRP = i / 3;
      localparam int CH  = i % 3;
      localparam int RT  = 3*GRP + ((CH == 0) ? 0 : (CH == 1) ? 2 : 1);
      if (3*GRP + 2 < NUM_TAPS) begin : g_rgb
         assign vrgb = LANE_W'(taps[RT*TAP_W +: TAP_W]);
      end else begin : g_rgbz
         assign vrgb = '0;
      end

      always_comb begin
         case (fmt)
            FMT_MONO8:  lanes[i*LANE_W +: LANE_W] = v8;
            FMT_MONO16: lanes[i*LANE_W +: LANE_W] = v16;
            FMT_PACK12: lanes[i*LANE_W +: LANE_W] = v12;
            default:    lanes[i*LANE_W +: LANE_W] = vrgb;
         endcase
      end
   end

endmodule

// File: rtl/tpu_out_reg.sv
module tpu_out_reg
   import tpu_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  qual_t                    qual_i,
   input  logic [LANES-1:0]         mask_i,
   input  logic                     err_i,
   input  logic [LANES*LANE_W-1:0]  lanes_i,
   output qual_t                    qual_o,
   output logic [LANES-1:0]         mask_o,
   output logic                     err_o,
   output logic [LANES*LANE_W-1:0]  lanes_o
);

   logic take;
   logic started;

   assign take = qual_i.fv && qual_i.lv && qual_i.dv && !err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_o  <= '0;
         mask_o  <= '0;
         err_o   <= 1'b0;
         lanes_o <= '0;
         started <= 1'b0;
      end else begin
         started <= 1'b1;
         qual_o  <= qual_i;
         err_o   <= err_i;
         mask_o  <= take ? mask_i : '0;
         if (take) begin
            lanes_o <= lanes_i;
         end
      end
   end

   // R6
   qual_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (qual_o == $past(qual_i)));

   // R7
   unqual_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(qual_i.fv && qual_i.lv && qual_i.dv)) |-> (mask_o == '0));

   // R7
   unqual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(qual_i.fv && qual_i.lv && qual_i.dv)) |-> $stable(lanes_o));

   // R8
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (mask_o == '0));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(err_i)) |-> $stable(lanes_o));

   // R5
   mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((mask_o + 1'b1) & mask_o) == '0));

endmodule

// File: rtl/tap_pixel_unpacker.sv
module tap_pixel_unpacker
   import tpu_pkg::*;
#(
   parameter int TAP_W     = 8,
   parameter int NUM_TAPS  = 8,
   parameter int LANE_W    = 16,
   parameter int BASE_TAPS = 3,
   parameter int MED_TAPS  = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    pix_fmt_i,
   input  logic [1:0]                    bus_cfg_i,
   input  logic [NUM_TAPS*TAP_W-1:0]     tap_data_i,
   input  logic                          fv_i,
   input  logic                          lv_i,
   input  logic                          dv_i,
   output logic                          fv_o,
   output logic                          lv_o,
   output logic                          dv_o,
   output logic [NUM_TAPS*LANE_W-1:0]    lane_data_o,
   output logic [NUM_TAPS-1:0]           lane_vld_o,
   output logic                          cfg_err_o
);

   localparam int LANES = NUM_TAPS;

   if (LANE_W < 2*TAP_W) begin : g_bad_lane
      $error("LANE_W must hold two taps");
   end
   if (NUM_TAPS < 6) begin : g_bad_taps
      $error("packed 12-bit layout needs at least six taps");
   end
   if (BASE_TAPS < 3 || BASE_TAPS > MED_TAPS || MED_TAPS > NUM_TAPS) begin : g_bad_bus
      $error("bus tap counts must rise from narrow to wide");
   end
   if (TAP_W % 2 != 0) begin : g_bad_nib
      $error("TAP_W must split into two nibbles");
   end

   pix_fmt_e               fmt;
   bus_cfg_e               bus;
   qual_t                  q_in, q_out;
   logic [LANES-1:0]       mask_c;
   logic                   err_c;
   logic [LANES*LANE_W-1:0] lanes_c;

   assign fmt  = pix_fmt_e'(pix_fmt_i);
   assign bus  = bus_cfg_e'(bus_cfg_i);
   assign q_in = '{fv: fv_i, lv: lv_i, dv: dv_i};

   tpu_cfg_decode #(
      .NUM_TAPS (NUM_TAPS),
      .BASE_TAPS(BASE_TAPS),
      .MED_TAPS (MED_TAPS),
      .LANES    (LANES)
   ) cfg_i (
      .fmt    (fmt),
      .bus    (bus),
      .mask   (mask_c),
      .cfg_err(err_c)
   );

   tpu_lane_mux #(
      .TAP_W   (TAP_W),
      .NUM_TAPS(NUM_TAPS),
      .LANES   (LANES),
      .LANE_W  (LANE_W)
   ) mux_i (
      .fmt  (fmt),
      .taps (tap_data_i),
      .lanes(lanes_c)
   );

   tpu_out_reg #(
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) oreg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .qual_i (q_in),
      .mask_i (mask_c),
      .err_i  (err_c),
      .lanes_i(lanes_c),
      .qual_o (q_out),
      .mask_o (lane_vld_o),
      .err_o  (cfg_err_o),
      .lanes_o(lane_data_o)
   );

   assign fv_o = q_out.fv;
   assign lv_o = q_out.lv;
   assign dv_o = q_out.dv;

   // R8
   rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_cfg_i == 2'd3) |-> cfg_err_o);

endmodule

// File: tb/tap_pixel_unpacker_tb.sv
module tap_pixel_unpacker_tb_top;

   localparam int CLK_PER = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   fmt = '0, bus = '0;
   logic [63:0]  word = '0;
   logic         fv = 1'b0, lv = 1'b0, dv = 1'b0;
   logic         fv_o, lv_o, dv_o, err_o;
   logic [127:0] lanes_o;
   logic [7:0]   vld_o;

   int checks = 0;
   int errors = 0;

   logic [15:0] held [8];
   logic [7:0]  held_mask = '0;

   always #(CLK_PER/2) clk = ~clk;

   tap_pixel_unpacker dut_i (
      .clk(clk), .rst_n(rst_n), .pix_fmt_i(fmt), .bus_cfg_i(bus),
      .tap_data_i(word), .fv_i(fv), .lv_i(lv), .dv_i(dv),
      .fv_o(fv_o), .lv_o(lv_o), .dv_o(dv_o),
      .lane_data_o(lanes_o), .lane_vld_o(vld_o), .cfg_err_o(err_o)
   );

   function automatic int taps_of(logic [1:0] b);
      case (b)
         2'd0: return 3;
         2'd1: return 6;
         2'd2: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic int need_of(logic [1:0] f);
      return (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 3;
   endfunction

   function automatic int count_of(logic [1:0] f, logic [1:0] b);
      int t = taps_of(b);
      case (f)
         2'd0: return t;
         2'd1: return (t == 3) ? 1 : (t == 6) ? 3 : 4;
         2'd2: return (t == 3) ? 2 : 4;
         default: return (t == 3) ? 3 : 6;
      endcase
   endfunction

   function automatic logic [7:0] tap(logic [63:0] w, int k);
      return w[8*k +: 8];
   endfunction

   function automatic logic [15:0] model_lane(logic [1:0] f, logic [63:0] w, int i);
      int lo_idx [4] = '{0, 2, 4, 3};
      int rgb_idx [6] = '{0, 2, 1, 3, 5, 4};
      logic [3:0] nib;
      case (f)
         2'd0: return {8'h00, tap(w, i)};
         2'd1: return {tap(w, 2*i+1), tap(w, 2*i)};
         2'd2: begin
            nib = (i < 2) ? ((i == 0) ? tap(w,1)[3:0] : tap(w,1)[7:4])
                          : ((i == 2) ? tap(w,5)[3:0] : tap(w,5)[7:4]);
            return {4'h0, nib, tap(w, lo_idx[i])};
         end
         default: return {8'h00, tap(w, rgb_idx[i])};
      endcase
   endfunction

   function automatic string tag_of(logic [1:0] f);
      return (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : (f == 2'd2) ? "R3" : "R4";
   endfunction

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive at negedge, one clock edge, compare at the next negedge.
   task automatic step(logic [1:0] f, logic [1:0] b, logic [63:0] w, logic [2:0] q);
      bit err_e, take;
      logic [7:0] mask_e;
      int n;
      fmt = f; bus = b; word = w; {fv, lv, dv} = q;
      @(posedge clk);
      @(negedge clk);
      err_e = need_of(f) > taps_of(b);
      take = (q == 3'b111) && !err_e;
      n = count_of(f, b);
      mask_e = take ? 8'((16'd1 << n) - 16'd1) : 8'h00;
      if (take) begin
         for (int i = 0; i < 8; i++) begin
            if (mask_e[i]) held[i] = model_lane(f, w, i);
         end
         held_mask = mask_e;
      end
      // R6 qualifier pass-through
      check({fv_o, lv_o, dv_o} == q, "R6", {fv_o, lv_o, dv_o}, q);
      // R8 error flag
      check(err_o == err_e, "R8", err_o, err_e);
      // R5 / R7 / R8 mask
      check(vld_o == mask_e, err_e ? "R8" : (q != 3'b111) ? "R7" : "R5", vld_o, mask_e);
      for (int i = 0; i < 8; i++) begin
         if (held_mask[i]) begin
            check(lanes_o[16*i +: 16] == held[i], take ? tag_of(f) : "R7",
                  lanes_o[16*i +: 16], held[i]);
         end
      end
   endtask

   initial begin
      logic [63:0] pat;
      void'($urandom(32'd20240611));
      #(CLK_PER*3);
      // R9 reset state
      check({fv_o, lv_o, dv_o, err_o} == 4'b0, "R9", {fv_o, lv_o, dv_o, err_o}, 0);
      check(vld_o == 8'h0 && lanes_o == '0, "R9", {vld_o, lanes_o}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      pat = 64'h8877_6655_4433_2211;
      for (int f = 0; f < 4; f++) begin
         for (int b = 0; b < 3; b++) begin
            step(2'(f), 2'(b), pat ^ {8{8'(16*f + b)}}, 3'b111);
         end
      end
      // R3 explicit 12-bit corner: distinct nibbles
      step(2'd2, 2'd1, 64'h0000_A5EE_DDCC_B2AA, 3'b111);
      check(lanes_o[15:0] == 16'h02AA && lanes_o[31:16] == 16'h0BCC &&
            lanes_o[47:32] == 16'h05EE && lanes_o[63:48] == 16'h0ADD,
            "R3", lanes_o[63:0], 64'h0ADD_05EE_0BCC_02AA);
      // R4 explicit colour order
      step(2'd3, 2'd0, 64'h0000_0000_0033_2211, 3'b111);
      check(lanes_o[47:0] == 48'h0022_0033_0011, "R4", lanes_o[47:0], 48'h0022_0033_0011);
      // R7 each qualifier low alone
      step(2'd0, 2'd2, 64'hDEAD_BEEF_0123_4567, 3'b011);
      step(2'd0, 2'd2, 64'h1111_2222_3333_4444, 3'b101);
      step(2'd1, 2'd2, 64'h5555_6666_7777_8888, 3'b110);
      // R8 reserved bus while fully qualified, every format
      for (int f = 0; f < 4; f++) step(2'(f), 2'd3, 64'hFFFF_0000_FFFF_0000, 3'b111);
      // recovery on first legal word
      step(2'd1, 2'd0, 64'h0000_0000_00C3_5A96, 3'b111);

      for (int n = 0; n < 3000; n++) begin
         logic [2:0] q;
         q = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b111;
         step(2'($urandom), ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
              {$urandom, $urandom}, q);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PER*200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule